// File: doc/BRIEF.md
# Stop-Grant Power-State Sequencer

This block sits in a system controller and reacts to power-management special cycles sent by one or two processors. Each special cycle reaches the block as a single-cycle message carrying the sending processor's number and an encoded data value. The address match has already been made upstream. A halt message is passed on to the I/O bus request port and nothing more. A stop-grant message is collected from every installed processor. When the last one arrives, the block forwards one stop-grant cycle to the I/O bus.

If the disconnect-enable configuration bit is set, the block then quiesces the system. It freezes peripheral and graphics arbitration and waits until the memory queues are empty, including refresh. It then waits for outstanding processor bus cycles to finish, asks for the processor disconnect, and finally asks memory to enter self-refresh. Every step is a level request answered by an acknowledge. On a wake input the block undoes the sequence in reverse order: self-refresh exit, then reconnect, then arbitration re-enable. After that it clears its record of received stop-grants.

If the disconnect-enable bit is clear, the block only forwards the stop-grant and holds until wake. Stop-grant may arrive at any moment while the processors run, so the sequence always starts from the running state.

Top module: `stopgrant_seq`

## Requirements
- R1: A message with data 0x01 (halt) makes `io_special_req` high for exactly one cycle, with `io_special_type` = 2'b01, on the clock edge after the message. `pwr_state`, `arb_disable`, `disconnect_req` and `selfrefresh_req` remain unchanged.
- R2: A message whose data is neither 0x01 nor 0x02 raises no I/O request and leaves `pwr_state` unchanged.
- R3: With `second_cpu_present` = 1, a stop-grant (data 0x02) from only one processor raises no I/O request and keeps `pwr_state` at RUN (0). The stop-grant from the other processor then produces one request with type 2'b10 on the next edge.
- R4: With `second_cpu_present` = 0, a stop-grant from processor 0 alone is forwarded. A stop-grant from processor 1 is ignored.
- R5: With `disconnect_en` = 0, a forwarded stop-grant moves `pwr_state` to HOLD (1). `arb_disable`, `disconnect_req` and `selfrefresh_req` stay low, and `wake` returns the state to RUN.
- R6: With `disconnect_en` = 1, the forwarding edge also raises `arb_disable` and enters QUIESCE (2). The state leaves QUIESCE for FINISH (3) only when `arb_idle_ack` and `queues_empty` are both high.
- R7: `disconnect_req` rises, entering DISC (4), only after `bus_cycles_done` is seen in FINISH. `selfrefresh_req` rises, entering SREF (5), only after `disconnect_ack`. `selfrefresh_ack` then enters ASLEEP (6).
- R8: A repeated stop-grant from a processor that has already sent one before wake is ignored and raises no I/O request.
- R9: `wake` in ASLEEP drops `selfrefresh_req` first (EXIT_SR, 7). `disconnect_req` drops after `selfrefresh_ack` falls (RECON, 8). `arb_disable` drops after `disconnect_ack` falls (REARB, 9). The state reaches RUN after `arb_idle_ack` falls. The received stop-grant flags are then clear, so a single processor's stop-grant is not forwarded again.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| cpu_special_valid | input | 1 | Special-cycle message valid this cycle |
| cpu_id | input | ID_W | Number of the processor sending the message |
| encoded_data | input | DATA_W | Special-cycle code |
| second_cpu_present | input | 1 | Processor 1 is installed |
| disconnect_en | input | 1 | Run the disconnect sequence on stop-grant |
| arb_idle_ack | input | 1 | Arbitration frozen acknowledge |
| queues_empty | input | 1 | All memory queues and refresh requests empty |
| bus_cycles_done | input | 1 | Outstanding processor bus cycles finished |
| disconnect_ack | input | 1 | Processor disconnect acknowledge |
| selfrefresh_ack | input | 1 | Memory in self-refresh acknowledge |
| wake | input | 1 | Wake-up event |
| io_special_req | output | 1 | One-cycle request to the I/O bus |
| io_special_type | output | 2 | 01 halt, 10 stop-grant |
| arb_disable | output | 1 | Freeze peripheral/graphics arbitration |
| disconnect_req | output | 1 | Request processor disconnect |
| selfrefresh_req | output | 1 | Request memory self-refresh |
| pwr_state | output | 4 | Sequencer state code |

## Verification
The bench targets the partial stop-grant case. A design that forwarded on the first processor's message would emit a stop-grant cycle too early. It also sends a duplicate from the same processor, which a flag-less design would count as the second processor. The quiesce steps are released one acknowledge at a time, with `queues_empty` held low while arbitration is already idle. A design that ignored the queues, or reordered disconnect and self-refresh, would show a request one step early. After the wake unwind, a single stop-grant is sent again; a design that failed to clear its flags would forward it.

// File: rtl/psq_pkg.sv
// Shared codes and state encoding for the stop-grant sequencer.
// Assumes an 8-bit special-cycle code space, widened by users as needed.
package psq_pkg;
    localparam logic [7:0] CODE_HALT    = 8'h01;
    localparam logic [7:0] CODE_STOPGNT = 8'h02;

    localparam logic [1:0] IO_HALT    = 2'b01;
    localparam logic [1:0] IO_STOPGNT = 2'b10;

    typedef enum logic [3:0] {
        ST_RUN     = 4'd0,
        ST_HOLD    = 4'd1,
        ST_QUIESCE = 4'd2,
        ST_FINISH  = 4'd3,
        ST_DISC    = 4'd4,
        ST_SREF    = 4'd5,
        ST_ASLEEP  = 4'd6,
        ST_EXIT_SR = 4'd7,
        ST_RECON   = 4'd8,
        ST_REARB   = 4'd9
    } pstate_t;
endpackage

// File: rtl/psq_decode.sv
// Classifies one special-cycle message as halt, stop-grant or unknown.
// Assumes the address match was done upstream; purely combinational.
module psq_decode #(
    parameter int DATA_W = 8
) (
    input  logic              valid,
    input  logic [DATA_W-1:0] data,
    output logic              is_halt,
    output logic              is_stopgnt
);
    import psq_pkg::*;

    // Compare the code against the two recognised encodings.
    always_comb begin
        is_halt    = valid && (data == DATA_W'(CODE_HALT));
        is_stopgnt = valid && (data == DATA_W'(CODE_STOPGNT));
    end
endmodule

// File: rtl/psq_sg_track.sv
// Keeps one stop-grant flag per processor and reports when a message
// completes the set of installed processors. Processor 0 is always installed.
// Assumes flags only update while enable is high (running state).
module psq_sg_track #(
    parameter int NUM_CPU = 2,
    parameter int ID_W    = 1
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            enable,
    input  logic            clr,
    input  logic            is_stopgnt,
    input  logic [ID_W-1:0] cpu_id,
    input  logic            second_present,
    output logic            complete
);
    logic [NUM_CPU-1:0] flag_q;
    logic [NUM_CPU-1:0] present;
    logic [NUM_CPU-1:0] hit;
    logic [NUM_CPU-1:0] after;

    for (genvar i = 0; i < NUM_CPU; i++) begin : g_cpu
        if (i == 0) begin : g_boot
            assign present[i] = 1'b1;
        end else begin : g_extra
            assign present[i] = second_present;
        end
        assign hit[i] = enable && is_stopgnt && present[i] && (cpu_id == ID_W'(i));

        // Set the flag on a first stop-grant, clear it on request.
        always_ff @(posedge clk) begin
            if (!rst_n || clr) flag_q[i] <= 1'b0;
            else if (hit[i])   flag_q[i] <= 1'b1;
        end
    end

    // A new, non-duplicate message that leaves every installed flag set.
    always_comb begin
        after    = flag_q | hit;
        complete = (|(hit & ~flag_q)) && (&(after | ~present));
    end
endmodule

// File: rtl/psq_fsm.sv
// Quiesce and wake sequencer. Each step holds a level request until its
// acknowledge arrives; the unwind waits for each acknowledge to drop.
module psq_fsm (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       sg_complete,
    input  logic       disconnect_en,
    input  logic       arb_idle_ack,
    input  logic       queues_empty,
    input  logic       bus_cycles_done,
    input  logic       disconnect_ack,
    input  logic       selfrefresh_ack,
    input  logic       wake,
    output logic       in_run,
    output logic       clr_flags,
    output logic       arb_disable,
    output logic       disconnect_req,
    output logic       selfrefresh_req,
    output logic [3:0] state
);
    import psq_pkg::*;

    pstate_t st_q, st_d;

    // Next-state selection.
    always_comb begin
        st_d = st_q;
        unique case (st_q)
            ST_RUN:     if (sg_complete) st_d = disconnect_en ? ST_QUIESCE : ST_HOLD;
            ST_HOLD:    if (wake) st_d = ST_RUN;
            ST_QUIESCE: if (arb_idle_ack && queues_empty) st_d = ST_FINISH;
            ST_FINISH:  if (bus_cycles_done) st_d = ST_DISC;
            ST_DISC:    if (disconnect_ack) st_d = ST_SREF;
            ST_SREF:    if (selfrefresh_ack) st_d = ST_ASLEEP;
            ST_ASLEEP:  if (wake) st_d = ST_EXIT_SR;
            ST_EXIT_SR: if (!selfrefresh_ack) st_d = ST_RECON;
            ST_RECON:   if (!disconnect_ack) st_d = ST_REARB;
            ST_REARB:   if (!arb_idle_ack) st_d = ST_RUN;
            default:    st_d = ST_RUN;
        endcase
    end

    // State register.
    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= ST_RUN;
        else        st_q <= st_d;
    end

    // Moore outputs and flag clearing.
    always_comb begin
        in_run          = (st_q == ST_RUN);
        clr_flags       = (wake && (st_q == ST_RUN || st_q == ST_HOLD))
                       || (st_q == ST_REARB && !arb_idle_ack);
        arb_disable     = (st_q inside {ST_QUIESCE, ST_FINISH, ST_DISC, ST_SREF,
                                        ST_ASLEEP, ST_EXIT_SR, ST_RECON});
        disconnect_req  = (st_q inside {ST_DISC, ST_SREF, ST_ASLEEP, ST_EXIT_SR});
        selfrefresh_req = (st_q inside {ST_SREF, ST_ASLEEP});
        state           = st_q;
    end
endmodule

// File: rtl/stopgrant_seq.sv
// Top of the stop-grant power-state sequencer. Decodes processor special
// cycles, forwards halt and completed stop-grant to the I/O bus as a one-cycle
// request, and drives the quiesce/wake handshakes. Only one message per cycle.
module stopgrant_seq #(
    parameter int NUM_CPU = 2,
    parameter int DATA_W  = 8,
    localparam int ID_W   = (NUM_CPU > 1) ? $clog2(NUM_CPU) : 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cpu_special_valid,
    input  logic [ID_W-1:0]   cpu_id,
    input  logic [DATA_W-1:0] encoded_data,
    input  logic              second_cpu_present,
    input  logic              disconnect_en,
    input  logic              arb_idle_ack,
    input  logic              queues_empty,
    input  logic              bus_cycles_done,
    input  logic              disconnect_ack,
    input  logic              selfrefresh_ack,
    input  logic              wake,
    output logic              io_special_req,
    output logic [1:0]        io_special_type,
    output logic              arb_disable,
    output logic              disconnect_req,
    output logic              selfrefresh_req,
    output logic [3:0]        pwr_state
);
    import psq_pkg::*;

    logic is_halt, is_stopgnt, sg_complete, in_run, clr_flags;

    psq_decode #(.DATA_W(DATA_W)) u_dec (
        .valid      (cpu_special_valid),
        .data       (encoded_data),
        .is_halt    (is_halt),
        .is_stopgnt (is_stopgnt)
    );

    psq_sg_track #(.NUM_CPU(NUM_CPU), .ID_W(ID_W)) u_trk (
        .clk            (clk),
        .rst_n          (rst_n),
        .enable         (in_run),
        .clr            (clr_flags),
        .is_stopgnt     (is_stopgnt),
        .cpu_id         (cpu_id),
        .second_present (second_cpu_present),
        .complete       (sg_complete)
    );

    psq_fsm u_fsm (
        .clk             (clk),
        .rst_n           (rst_n),
        .sg_complete     (sg_complete),
        .disconnect_en   (disconnect_en),
        .arb_idle_ack    (arb_idle_ack),
        .queues_empty    (queues_empty),
        .bus_cycles_done (bus_cycles_done),
        .disconnect_ack  (disconnect_ack),
        .selfrefresh_ack (selfrefresh_ack),
        .wake            (wake),
        .in_run          (in_run),
        .clr_flags       (clr_flags),
        .arb_disable     (arb_disable),
        .disconnect_req  (disconnect_req),
        .selfrefresh_req (selfrefresh_req),
        .state           (pwr_state)
    );

    // Register the one-cycle I/O bus request and its type.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            io_special_req  <= 1'b0;
            io_special_type <= 2'b00;
        end else begin
            io_special_req  <= is_halt || sg_complete;
            io_special_type <= is_halt ? IO_HALT : (sg_complete ? IO_STOPGNT : 2'b00);
        end
    end
endmodule

// File: rtl/stopgrant_seq_chk.sv
// Protocol checker for stopgrant_seq, attached with bind below.
module stopgrant_seq_chk #(
    parameter int DATA_W = 8
) (
    input logic              clk,
    input logic              rst_n,
    input logic              cpu_special_valid,
    input logic [DATA_W-1:0] encoded_data,
    input logic              wake,
    input logic              disconnect_ack,
    input logic              bus_cycles_done,
    input logic              io_special_req,
    input logic [1:0]        io_special_type,
    input logic              arb_disable,
    input logic              disconnect_req,
    input logic              selfrefresh_req,
    input logic [3:0]        pwr_state
);
    import psq_pkg::*;

    logic msg_halt, msg_unknown;
    assign msg_halt    = cpu_special_valid && encoded_data == DATA_W'(CODE_HALT);
    assign msg_unknown = cpu_special_valid && encoded_data != DATA_W'(CODE_HALT)
                      && encoded_data != DATA_W'(CODE_STOPGNT);

    a_r1_halt_forward: assert property (@(posedge clk) disable iff (!rst_n)
        msg_halt && pwr_state == 4'd0 |=> io_special_req && io_special_type == IO_HALT
                                          && pwr_state == 4'd0 && !arb_disable);

    a_r2_unknown_ignored: assert property (@(posedge clk) disable iff (!rst_n)
        msg_unknown && pwr_state == 4'd0 |=> !io_special_req && pwr_state == 4'd0);

    a_r5_hold_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        pwr_state == 4'd1 |-> !arb_disable && !disconnect_req && !selfrefresh_req);

    a_r7_disc_after_cycles: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(disconnect_req) |-> arb_disable && $past(bus_cycles_done));

    a_r7_sref_after_disc: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(selfrefresh_req) |-> disconnect_req && $past(disconnect_ack));

    a_r9_release_order: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(arb_disable) |-> !disconnect_req && !selfrefresh_req);

    a_r9_sref_first: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(disconnect_req) |-> !selfrefresh_req);
endmodule

bind stopgrant_seq stopgrant_seq_chk #(.DATA_W(DATA_W)) u_chk (
    .clk               (clk),
    .rst_n             (rst_n),
    .cpu_special_valid (cpu_special_valid),
    .encoded_data      (encoded_data),
    .wake              (wake),
    .disconnect_ack    (disconnect_ack),
    .bus_cycles_done   (bus_cycles_done),
    .io_special_req    (io_special_req),
    .io_special_type   (io_special_type),
    .arb_disable       (arb_disable),
    .disconnect_req    (disconnect_req),
    .selfrefresh_req   (selfrefresh_req),
    .pwr_state         (pwr_state)
);

// File: tb/tb_stopgrant_seq.sv
// Scoreboard bench: send() queues expected I/O requests, monitor pops them.
module tb_stopgrant_seq;
    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic cpu_special_valid = 1'b0;
    logic [0:0] cpu_id = 1'b0;
    logic [7:0] encoded_data = 8'h00;
    logic second_cpu_present = 1'b1, disconnect_en = 1'b1;
    logic arb_idle_ack = 1'b0, queues_empty = 1'b0, bus_cycles_done = 1'b0;
    logic disconnect_ack = 1'b0, selfrefresh_ack = 1'b0, wake = 1'b0;
    logic io_special_req, arb_disable, disconnect_req, selfrefresh_req;
    logic [1:0] io_special_type;
    logic [3:0] pwr_state;

    int tests = 0, fails = 0;
    bit done = 1'b0;
    logic [1:0] exp_q[$];

    always #2.5 clk = ~clk;

    stopgrant_seq dut (.*);

    task automatic check(input string req, input int act, input int exp);
        tests++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic send(input logic id, input logic [7:0] d, input logic [1:0] expect_type);
        if (expect_type != 2'b00) exp_q.push_back(expect_type);
        @(negedge clk);
        cpu_special_valid = 1'b1; cpu_id = id; encoded_data = d;
        @(negedge clk);
        cpu_special_valid = 1'b0;
    endtask

    task automatic step(); @(negedge clk); endtask

    // Monitor: every I/O request must match the head of the expected queue.
    always @(negedge clk) begin
        if (rst_n && io_special_req) begin
            if (exp_q.size() == 0) check("R2/R3/R8 unexpected io request", 1, 0);
            else check("R1/R3 io type", int'(io_special_type), int'(exp_q.pop_front()));
        end
    end

    initial begin
        repeat (4) step();
        check("R1 reset state", pwr_state, 0);
        check("R6 reset arb", arb_disable, 0);
        rst_n = 1'b1;
        step();
        send(1'b0, 8'h01, 2'b01);
        check("R1 halt keeps state", pwr_state, 0);
        check("R1 halt no arb", arb_disable, 0);
        send(1'b0, 8'h55, 2'b00);
        check("R2 unknown keeps state", pwr_state, 0);
        send(1'b0, 8'h02, 2'b00);
        check("R3 one cpu waits", pwr_state, 0);
        send(1'b0, 8'h02, 2'b00);
        check("R8 duplicate ignored", pwr_state, 0);
        send(1'b1, 8'h02, 2'b10);
        check("R6 quiesce entered", pwr_state, 2);
        check("R6 arb disabled", arb_disable, 1);
        arb_idle_ack = 1'b1;
        step(); step();
        check("R6 waits for queues", pwr_state, 2);
        queues_empty = 1'b1;
        step();
        check("R6 finish state", pwr_state, 3);
        check("R7 no early disconnect", disconnect_req, 0);
        bus_cycles_done = 1'b1;
        step();
        check("R7 disconnect req", disconnect_req, 1);
        check("R7 no early sref", selfrefresh_req, 0);
        disconnect_ack = 1'b1;
        step();
        check("R7 sref req", selfrefresh_req, 1);
        selfrefresh_ack = 1'b1;
        step();
        check("R7 asleep", pwr_state, 6);
        wake = 1'b1;
        step();
        wake = 1'b0;
        check("R9 sref dropped", selfrefresh_req, 0);
        check("R9 disc held", disconnect_req, 1);
        selfrefresh_ack = 1'b0;
        step();
        check("R9 reconnect", disconnect_req, 0);
        check("R9 arb still off", arb_disable, 1);
        disconnect_ack = 1'b0;
        step();
        check("R9 arb re-enabled", arb_disable, 0);
        arb_idle_ack = 1'b0; queues_empty = 1'b0; bus_cycles_done = 1'b0;
        step();
        check("R9 back to run", pwr_state, 0);
        send(1'b1, 8'h02, 2'b00);
        check("R9 flags cleared", pwr_state, 0);
        wake = 1'b1; step(); wake = 1'b0;
        second_cpu_present = 1'b0; disconnect_en = 1'b0;
        send(1'b1, 8'h02, 2'b00);
        check("R4 absent cpu ignored", pwr_state, 0);
        send(1'b0, 8'h02, 2'b10);
        check("R5 hold state", pwr_state, 1);
        step(); step();
        check("R5 no arb disable", arb_disable, 0);
        check("R5 no disconnect", disconnect_req, 0);
        wake = 1'b1; step(); wake = 1'b0;
        check("R5 wake to run", pwr_state, 0);
        step();
        check("R3 all expected requests seen", exp_q.size(), 0);
        done = 1'b1;
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

    // Watchdog: a hung run counts as a failure.
    initial begin
        repeat (5000) @(posedge clk);
        if (!done) begin
            tests++; fails++;
            $display("FAIL watchdog actual=hung expected=done");
            $display("[TB] %0d tests run, %0d failed", tests, fails);
            $finish;
        end
    end
endmodule